// File: doc/BRIEF.md
# Smart Card Answer-To-Reset Parser

This block listens passively to the byte stream a smart card sends after its reset line is released. Bytes arrive already framed, one per cycle of `byte_valid`. Each byte is classified as the initial character, the format byte, an interface byte of group A, B, C or D, a historical byte or the closing check byte. Every accepted byte is written in arrival order into a 64-entry buffer, which a neighbour reads through a combinational read port.

Along the way the parser picks up the waiting-time integer from the right C-group byte. When the check byte arrives it emits a one-cycle completion pulse. At that edge it also latches the work waiting time, computed from the current rate-adjustment code and that integer. The check byte is not verified. Inverse-convention decoding and bit-level reception belong to other blocks.

States: `S_IDLE` (card held in reset), `S_TS` (awaiting the initial character), `S_T0` (format byte), `S_TA`, `S_TB`, `S_TC`, `S_TD` (interface bytes), `S_HIST` (historical bytes), `S_TCK` (check byte) and `S_DONE` (answer complete).

Transitions:
- Any state goes to `S_IDLE` while `card_rst_n` is low.
- `S_IDLE` goes to `S_TS` on release, clearing all parser state.
- `S_TS` goes to `S_T0` on a nonzero byte.
- `S_T0` and `S_TD` go to the first announced interface state, scanning from A.
- `S_TA`, `S_TB` and `S_TC` go to the next announced state after their own group.
- When no group is left, the scan goes to `S_HIST`, or to `S_TCK` if the historical count is zero.
- `S_HIST` goes to `S_TCK` after its last byte.
- `S_TCK` goes to `S_DONE`.

Top module: `atr_parser`

## Requirements
- R1: While `card_rst_n` is low the parser is idle. `atr_active` is low one cycle after it falls, and bytes leave `byte_count` unchanged.
- R2: On the first cycle with `card_rst_n` high in idle, the following are cleared: `byte_count` to 0, `overflow` to 0, every buffer entry to 0x00, and `wi_value` to 10. The parser then waits for the initial character.
- R3: A byte of value 0x00 received while waiting for the initial character is discarded. It is not stored or counted, and the parser keeps waiting.
- R4: In the format byte, bits 3:0 give the number of historical bytes and bits 7:4 form the first presence indicator. Indicator bit 4 announces an A byte, bit 5 a B byte, bit 6 a C byte and bit 7 a D byte. They are expected in that order, and absent ones are skipped.
- R5: Each D byte replaces the stored indicator with its bits 7:4, and the scan restarts at the A group.
- R6: A C byte is latched into `wi_value` only when bits 3:0 of the most recent D byte equal 2. A C byte before any D byte is never latched, and `wi_value` stays 10 without such a byte.
- R7: Each historical byte reduces the remaining count. After the last one, the next byte is the check byte. With a declared count of zero, the check byte follows the interface bytes directly.
- R8: At completion `wait_time` = 960 × D × `wi_value`. D is taken from `di_code` as follows: 1→1, 2→2, 3→4, 4→8, 5→16, 10→2, 11→4, 12→8, 13→16, 14→32, 15→64, any other code→0.
- R9: Accepted bytes are stored at consecutive indices from 0. `rd_data` shows the entry at `rd_addr` in the same cycle.
- R10: `byte_count` saturates at 64. A byte accepted with the buffer full is not stored and sets `overflow`, which stays set until the next release of card reset. Parsing continues.
- R11: `atr_done` is high for exactly one cycle, after the edge that accepts the check byte. Bytes after that leave `byte_count` unchanged until the card reset cycles.
- R12: With `byte_valid` low, `byte_data` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| card_rst_n | input | 1 | Sampled card reset line level, low = card held in reset |
| byte_valid | input | 1 | Qualifies `byte_data` for one cycle |
| byte_data | input | 8 | Received, already framed byte |
| di_code | input | 4 | Current rate-adjustment code used for the waiting time |
| rd_addr | input | 6 | Buffer read index |
| atr_active | output | 1 | Parser between release and completion |
| atr_done | output | 1 | One-cycle pulse at completion |
| byte_count | output | 7 | Number of bytes stored, 0 to 64 |
| overflow | output | 1 | Sticky flag: a byte arrived with the buffer full |
| wi_value | output | 8 | Waiting-time integer in effect |
| wait_time | output | 24 | Work waiting time latched at completion |
| rd_data | output | 8 | Buffer entry at `rd_addr` |

## Verification
The hardest condition to reach is the full buffer. A real answer is far shorter than 64 bytes, and the parser itself limits where a byte can go. The stimulus builds an answer whose format byte and every following D byte announce only another D byte. This keeps the parser in its interface-byte loop for seventy bytes, carrying the count past 64. A D byte with an empty indicator then closes the loop, and a check byte completes the answer. In a separate case, a C byte arrives both before and after a D byte with low nibble 2, to show that only the second is latched.

// File: rtl/atr_pkg.sv
package atr_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_TS,
        S_T0,
        S_TA,
        S_TB,
        S_TC,
        S_TD,
        S_HIST,
        S_TCK,
        S_DONE
    } atr_state_e;

    // Rate-adjustment factor for a 4-bit code, 0 for reserved codes
    function automatic logic [6:0] d_factor(input logic [3:0] code);
        logic [6:0] f;
        case (code)
            4'd1:    f = 7'd1;
            4'd2:    f = 7'd2;
            4'd3:    f = 7'd4;
            4'd4:    f = 7'd8;
            4'd5:    f = 7'd16;
            4'd10:   f = 7'd2;
            4'd11:   f = 7'd4;
            4'd12:   f = 7'd8;
            4'd13:   f = 7'd16;
            4'd14:   f = 7'd32;
            4'd15:   f = 7'd64;
            default: f = 7'd0;
        endcase
        return f;
    endfunction

    // First announced group at or after position 'from' (0=A .. 3=D)
    function automatic atr_state_e next_iface(input logic [3:0] ind,
                                              input logic [1:0] from,
                                              input logic       hist_zero);
        atr_state_e r;
        r = hist_zero ? S_TCK : S_HIST;
        for (int i = 3; i >= 0; i--) begin
            if (i >= int'(from) && ind[i]) begin
                case (i)
                    0:       r = S_TA;
                    1:       r = S_TB;
                    2:       r = S_TC;
                    default: r = S_TD;
                endcase
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/atr_buffer.sv
module atr_buffer #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 8,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    logic [DEPTH-1:0][DATA_W-1:0] cells;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        logic [DATA_W-1:0] cell_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                cell_q <= '0;
            else if (clr)
                cell_q <= '0;
            else if (wr_en && wr_addr == ADDR_W'(g))
                cell_q <= wr_data;
        end
        assign cells[g] = cell_q;
    end

    assign rd_data = cells[rd_addr];

    // R2: a clear leaves the addressed entry empty
    p_clear_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !wr_en) |=> (rd_data == '0 || $changed(rd_addr)));

endmodule

// File: rtl/atr_wtime.sv
module atr_wtime #(
    parameter int WT_W = 24,
    parameter int WI_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            load,
    input  logic [3:0]      di_code,
    input  logic [WI_W-1:0] wi,
    output logic [WT_W-1:0] wait_time
);
    import atr_pkg::*;

    localparam int ETU_BASE = 960;

    logic [WT_W-1:0] product;
    logic [WT_W-1:0] wt_q;

    always_comb begin
        product = WT_W'(ETU_BASE) * WT_W'(d_factor(di_code)) * WT_W'(wi);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            wt_q <= '0;
        else if (clr)
            wt_q <= '0;
        else if (load)
            wt_q <= product;
    end

    assign wait_time = wt_q;

    // R8: the value only moves at a completion or a new answer
    p_wt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !clr) |=> $stable(wait_time));

endmodule

// File: rtl/atr_ctrl.sv
module atr_ctrl #(
    parameter int DEPTH      = 64,
    parameter int WI_DEFAULT = 10,
    localparam int IDX_W  = $clog2(DEPTH + 1),
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              card_rst_n,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    output logic              active,
    output logic              done,
    output logic [IDX_W-1:0]  count,
    output logic              overflow,
    output logic [7:0]        wi,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              clr,
    output logic              load
);
    import atr_pkg::*;

    atr_state_e       state_q, state_d;
    logic [3:0]       ind_q, ind_d;
    logic [3:0]       tdlo_q, tdlo_d;
    logic [3:0]       hist_q, hist_d;
    logic [IDX_W-1:0] count_q, count_d;
    logic             ovf_q, ovf_d;
    logic [7:0]       wi_q, wi_d;
    logic             done_q, done_d;
    logic             accept;

    // Next-state and datapath selection
    always_comb begin
        state_d = state_q;
        ind_d   = ind_q;
        tdlo_d  = tdlo_q;
        hist_d  = hist_q;
        count_d = count_q;
        ovf_d   = ovf_q;
        wi_d    = wi_q;
        done_d  = 1'b0;
        clr     = 1'b0;
        load    = 1'b0;
        wr_en   = 1'b0;
        accept  = 1'b0;
        if (!card_rst_n) begin
            state_d = S_IDLE;
        end else if (state_q == S_IDLE) begin
            state_d = S_TS;
            clr     = 1'b1;
            ind_d   = '0;
            tdlo_d  = '0;
            hist_d  = '0;
            count_d = '0;
            ovf_d   = 1'b0;
            wi_d    = 8'(WI_DEFAULT);
        end else if (byte_valid && state_q != S_DONE &&
                     !(state_q == S_TS && byte_data == 8'h00)) begin
            accept = 1'b1;
            if (count_q < IDX_W'(DEPTH)) begin
                wr_en   = 1'b1;
                count_d = count_q + 1'b1;
            end else begin
                ovf_d = 1'b1;
            end
            unique case (state_q)
                S_TS: state_d = S_T0;
                S_T0: begin
                    ind_d   = byte_data[7:4];
                    tdlo_d  = 4'h0;
                    hist_d  = byte_data[3:0];
                    state_d = next_iface(byte_data[7:4], 2'd0, byte_data[3:0] == 4'h0);
                end
                S_TA: state_d = next_iface(ind_q, 2'd1, hist_q == 4'h0);
                S_TB: state_d = next_iface(ind_q, 2'd2, hist_q == 4'h0);
                S_TC: begin
                    if (tdlo_q == 4'h2)
                        wi_d = byte_data;
                    state_d = next_iface(ind_q, 2'd3, hist_q == 4'h0);
                end
                S_TD: begin
                    ind_d   = byte_data[7:4];
                    tdlo_d  = byte_data[3:0];
                    state_d = next_iface(byte_data[7:4], 2'd0, hist_q == 4'h0);
                end
                S_HIST: begin
                    hist_d  = hist_q - 4'h1;
                    state_d = (hist_q == 4'h1) ? S_TCK : S_HIST;
                end
                S_TCK: begin
                    state_d = S_DONE;
                    done_d  = 1'b1;
                    load    = 1'b1;
                end
                default: state_d = state_q;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            ind_q   <= '0;
            tdlo_q  <= '0;
            hist_q  <= '0;
            count_q <= '0;
            ovf_q   <= 1'b0;
            wi_q    <= 8'(WI_DEFAULT);
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            ind_q   <= ind_d;
            tdlo_q  <= tdlo_d;
            hist_q  <= hist_d;
            count_q <= count_d;
            ovf_q   <= ovf_d;
            wi_q    <= wi_d;
            done_q  <= done_d;
        end
    end

    // Outputs
    always_comb begin
        active   = (state_q != S_IDLE) && (state_q != S_DONE);
        done     = done_q;
        count    = count_q;
        overflow = ovf_q;
        wi       = wi_q;
        wr_addr  = count_q[ADDR_W-1:0];
    end

    p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !card_rst_n |=> (!active && $stable(count)));

    p_start_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && card_rst_n) |=>
            (count == '0 && !overflow && wi == 8'(WI_DEFAULT) && state_q == S_TS));

    p_zero_ts_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_TS && card_rst_n && byte_valid && byte_data == 8'h00) |=>
            (state_q == S_TS && $stable(count)));

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        count <= IDX_W'(DEPTH));

    p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && state_q != S_IDLE) |=> overflow);

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_after_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DONE && card_rst_n) |=> ($stable(count) && !done));

    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!byte_valid && state_q != S_IDLE) |=> $stable(count));

    p_accept_writes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !accept) |-> 1'b0);

endmodule

// File: rtl/atr_parser.sv
module atr_parser #(
    parameter int DEPTH      = 64,
    parameter int WT_W       = 24,
    parameter int WI_DEFAULT = 10
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       card_rst_n,
    input  logic                       byte_valid,
    input  logic [7:0]                 byte_data,
    input  logic [3:0]                 di_code,
    input  logic [$clog2(DEPTH)-1:0]   rd_addr,
    output logic                       atr_active,
    output logic                       atr_done,
    output logic [$clog2(DEPTH+1)-1:0] byte_count,
    output logic                       overflow,
    output logic [7:0]                 wi_value,
    output logic [WT_W-1:0]            wait_time,
    output logic [7:0]                 rd_data
);

    localparam int ADDR_W = $clog2(DEPTH);

    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic              clr;
    logic              load;

    atr_ctrl #(
        .DEPTH      (DEPTH),
        .WI_DEFAULT (WI_DEFAULT)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .card_rst_n (card_rst_n),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .active     (atr_active),
        .done       (atr_done),
        .count      (byte_count),
        .overflow   (overflow),
        .wi         (wi_value),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .clr        (clr),
        .load       (load)
    );

    atr_buffer #(
        .DEPTH  (DEPTH),
        .DATA_W (8)
    ) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (byte_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    atr_wtime #(
        .WT_W (WT_W),
        .WI_W (8)
    ) u_wt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .load      (load),
        .di_code   (di_code),
        .wi        (wi_value),
        .wait_time (wait_time)
    );

endmodule

// File: tb/atr_parser_bench.sv
module atr_parser_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        card_rst_n = 1'b0;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = 8'h00;
    logic [3:0]  di_code = 4'd1;
    logic [5:0]  rd_addr = '0;
    logic        atr_active;
    logic        atr_done;
    logic [6:0]  byte_count;
    logic        overflow;
    logic [7:0]  wi_value;
    logic [23:0] wait_time;
    logic [7:0]  rd_data;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct {
        int cnt;
        int wi;
        int wt;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;

    atr_parser u_atr_parser (
        .clk        (clk),
        .rst_n      (rst_n),
        .card_rst_n (card_rst_n),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .di_code    (di_code),
        .rd_addr    (rd_addr),
        .atr_active (atr_active),
        .atr_done   (atr_done),
        .byte_count (byte_count),
        .overflow   (overflow),
        .wi_value   (wi_value),
        .wait_time  (wait_time),
        .rd_data    (rd_data)
    );

    function automatic int dval(input int code);
        case (code)
            1: return 1;   2: return 2;   3: return 4;   4: return 8;
            5: return 16;  10: return 2;  11: return 4;  12: return 8;
            13: return 16; 14: return 32; 15: return 64;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        byte_valid = 1'b1;
        byte_data  = b;
        @(negedge clk);
        byte_valid = 1'b0;
        byte_data  = 8'h00;
    endtask

    task automatic expect_done(input int cnt, input int wi);
        exp_t e;
        e.cnt = cnt;
        e.wi  = wi;
        e.wt  = 960 * dval(int'(di_code)) * wi;
        sb.push_back(e);
    endtask

    task automatic card_cycle();
        @(negedge clk);
        card_rst_n = 1'b0;
        @(negedge clk);
        card_rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic read_at(input int a, input int exp, input string req);
        rd_addr = 6'(a);
        #1;
        chk(req, int'(rd_data), exp);
    endtask

    // Scoreboard monitor: every completion pulse is compared with the queue
    always @(negedge clk) begin
        if (rst_n && atr_done) begin
            if (sb.size() == 0) begin
                chk("R11 unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk("R7 length at done", int'(byte_count), e.cnt);
                chk("R6 wi at done", int'(wi_value), e.wi);
                chk("R8 wait_time", int'(wait_time), e.wt);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset active", int'(atr_active), 0);
        chk("R1 reset count", int'(byte_count), 0);
        chk("R1 reset done", int'(atr_done), 0);
        chk("R1 reset overflow", int'(overflow), 0);
        chk("R8 reset wait_time", int'(wait_time), 0);

        send(8'h3B);
        chk("R1 byte ignored in idle", int'(byte_count), 0);
        chk("R1 idle active", int'(atr_active), 0);

        @(negedge clk);
        card_rst_n = 1'b1;
        @(negedge clk);
        chk("R2 active after release", int'(atr_active), 1);
        chk("R2 count after release", int'(byte_count), 0);
        chk("R2 wi default", int'(wi_value), 10);

        // Answer A: no interface bytes, no historical bytes
        di_code = 4'd1;
        send(8'h00);
        chk("R3 zero before initial char", int'(byte_count), 0);
        send(8'h3B);
        send(8'h00);
        chk("R7 zero hist", int'(byte_count), 2);
        expect_done(3, 10);
        send(8'h55);
        @(negedge clk);
        chk("R11 done is single cycle", int'(atr_done), 0);
        chk("R11 inactive after done", int'(atr_active), 0);
        send(8'hAA);
        chk("R11 byte after done ignored", int'(byte_count), 3);
        read_at(0, 8'h3B, "R9 A[0]");
        read_at(1, 8'h00, "R9 A[1]");
        read_at(2, 8'h55, "R9 A[2]");

        card_cycle();
        chk("R2 count cleared", int'(byte_count), 0);
        read_at(0, 0, "R2 buffer cleared");

        // Answer B: C byte before and after a D byte with low nibble 2
        di_code = 4'd3;
        begin
            logic [7:0] b_bytes [10] = '{8'h3B, 8'hD2, 8'h11, 8'h20, 8'h52,
                                         8'h77, 8'h05, 8'h41, 8'h42, 8'h99};
            for (int i = 0; i < 9; i++) begin
                send(b_bytes[i]);
                if (i == 2) begin
                    @(negedge clk);
                    byte_data = 8'hFF;
                    repeat (2) @(negedge clk);
                    chk("R12 valid low ignored", int'(byte_count), 3);
                    byte_data = 8'h00;
                end
                if (i == 3) chk("R6 first C not latched", int'(wi_value), 10);
                if (i == 6) chk("R6 C after D2 latched", int'(wi_value), 5);
            end
            chk("R4 no early done", int'(atr_active), 1);
            expect_done(10, 5);
            send(b_bytes[9]);
            for (int i = 0; i < 10; i++)
                read_at(i, int'(b_bytes[i]), "R9 B stored in order");
        end

        card_cycle();

        // Answer C: D byte restarts scan at A, then B only, one hist byte
        di_code = 4'd11;
        send(8'h3B);
        send(8'h81);
        send(8'h20);
        send(8'h00);
        chk("R5 still active after B2", int'(atr_active), 1);
        send(8'h48);
        expect_done(6, 10);
        send(8'h11);

        // Abort in the middle: no completion is allowed
        card_cycle();
        send(8'h3B);
        send(8'h92);
        @(negedge clk);
        card_rst_n = 1'b0;
        @(negedge clk);
        chk("R1 abort goes idle", int'(atr_active), 0);
        send(8'h11);
        chk("R1 abort ignores bytes", int'(byte_count), 2);
        @(negedge clk);
        card_rst_n = 1'b1;
        @(negedge clk);

        // Answer D: endless D chain to overflow the buffer
        di_code = 4'd2;
        send(8'h3B);
        send(8'h80);
        for (int i = 0; i < 70; i++) begin
            send(8'h80);
            if (i == 61) begin
                chk("R10 full not yet overflow", int'(overflow), 0);
                chk("R10 count at full", int'(byte_count), 64);
            end
        end
        chk("R10 count saturated", int'(byte_count), 64);
        chk("R10 overflow set", int'(overflow), 1);
        read_at(63, 8'h80, "R10 last entry");
        send(8'h00);
        expect_done(64, 10);
        send(8'h22);
        chk("R10 overflow sticky", int'(overflow), 1);

        card_cycle();
        chk("R2 overflow cleared", int'(overflow), 0);

        // Answer E: largest factor and integer
        di_code = 4'd15;
        send(8'h3B);
        send(8'h80);
        send(8'h42);
        send(8'hFF);
        expect_done(5, 255);
        send(8'h33);
        repeat (2) @(negedge clk);

        chk("R11 all completions seen", sb.size(), 0);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule